// File: doc/BRIEF.md
# Flash Read Line Cache with Next-Line Prefetch

This block sits between host firmware reads and a serial flash read engine. The host presents a byte address with a valid flag and holds it until the block returns one 32-bit word with a one-cycle ready pulse. Behind the block, a flash-side port issues line fetches (64 bytes, streamed back as sixteen words in ascending order) or single-word fetches. The flash port issues one request at a time with a valid/ready handshake and takes its response as a valid-qualified word stream.

A two-bit policy input selects the operating mode. `00` caches without prefetch. `01` passes every read straight through as one single-word flash read and keeps the buffer empty. `10` caches and prefetches the next sequential line. `11` is a reserved code; it is treated as `00`, so prefetch is never enabled without caching. The buffer has two line entries, each with a tag and a valid bit. A demand miss fills the least recently used entry. A hit in prefetch mode fetches the next 64-byte-aligned line into the other entry, unless that line is already present. A one-cycle host write strobe, or the pass-through policy, clears every valid bit. A fill that was running when the buffer was cleared does not become valid.

A single state machine sequences all of this. Its states are:

- IDLE: looks up the request.
- DREQ and DFILL: issue and receive a demand line.
- WREQ and WWAIT: issue and receive one pass-through word.
- RESP: the ready pulse.
- PREQ and PFILL: issue and receive a prefetch line.

Its transitions are:

- IDLE goes to RESP on a hit, to DREQ on a cacheable miss, and to WREQ in pass-through.
- DREQ goes to DFILL, WREQ to WWAIT, and PREQ to PFILL, each on request acceptance.
- DFILL and WWAIT go to RESP when the last word arrives.
- RESP goes to PREQ when a prefetch is pending, and to IDLE otherwise.
- PFILL goes to IDLE after its last word.

Because a request that arrives during a prefetch waits in IDLE's input until PFILL completes, the prefetch always finishes before the demand fetch starts.

Top module: `fc_flash_line_cache`

## Requirements
- R1: During and right after reset, host_ready and fl_req_valid are 0 and no entry is valid, so the first cacheable read misses.
- R2: A cacheable miss issues one request with fl_req_line=1 and fl_req_addr set to the read address with bits 5:0 cleared. The returned word is the one at line offset addr[5:2].
- R3: A read in policy 00 to a line held in the buffer returns one cycle after it is presented, with data from the buffer and no flash request.
- R4: In policy 01, every host read issues exactly one request with fl_req_line=0 and fl_req_addr equal to the host address, and returns the word from that response.
- R5: Selecting policy 01 clears all valid bits, so a later read in policy 00 to a previously cached line fetches it again.
- R6: In policy 10, a hit on line L whose next line L+64 is absent issues a line request for L+64 after the hit response. A later read in L+64 then returns with no flash request.
- R7: Policy 11 behaves as 00: a hit never starts a prefetch.
- R8: A one-cycle host_write pulse clears all valid bits.
- R9: A demand miss presented while a prefetch is in flight is held until the prefetch has finished. Its own line request follows the prefetch request, and the read returns correct data.
- R10: In policy 10, a hit whose next line is already valid starts no prefetch.
- R11: While fl_req_valid is 1 and fl_req_ready is 0, the request stays asserted with fl_req_addr and fl_req_line unchanged.
- R12: host_ready is a single-cycle pulse per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | 00 cache, 01 pass-through, 10 cache+prefetch, 11 treated as 00 |
| host_req_valid | input | 1 | Host read request, held until host_ready |
| host_req_addr | input | ADDR_W | Host byte address |
| host_write | input | 1 | One-cycle strobe for a host write to firmware space; clears the buffer |
| host_ready | output | 1 | One-cycle pulse: host_rdata is valid |
| host_rdata | output | DATA_W | Returned word |
| fl_req_valid | output | 1 | Flash request valid |
| fl_req_addr | output | ADDR_W | Flash request byte address |
| fl_req_line | output | 1 | 1: 64-byte line (16 words), 0: single word |
| fl_req_ready | input | 1 | Flash engine accepts the request |
| fl_rsp_valid | input | 1 | Flash response word valid |
| fl_rsp_data | input | DATA_W | Flash response word |

## Verification
The bench stamps every flash word with a generation byte that it changes between scenarios. This lets it tell buffered data from freshly fetched data. A design that failed to invalidate on a pass-through policy or a write strobe would return an old generation instead of issuing a new request. It logs every flash request in order. This exposes a design that lets a demand fetch overtake an in-flight prefetch, one that prefetches under the reserved policy, and one that refetches a next line that is already valid. It also withholds request acceptance to catch a request that changes or drops before it is taken.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int FC_ENTRIES = 2;

    localparam logic [1:0] POL_CACHE = 2'b00;
    localparam logic [1:0] POL_PASS  = 2'b01;
    localparam logic [1:0] POL_PREF  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DREQ,
        ST_DFILL,
        ST_WREQ,
        ST_WWAIT,
        ST_RESP,
        ST_PREQ,
        ST_PFILL
    } fc_state_e;
endpackage

// File: rtl/fc_tag_track.sv
module fc_tag_track
    import fc_pkg::*;
#(
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lookup_tag,
    input  logic [TAG_W-1:0] next_tag,
    input  logic             clear_all,
    input  logic             alloc,
    input  logic             alloc_entry,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             commit,
    input  logic             commit_entry,
    input  logic             touch,
    input  logic             touch_entry,
    output logic             hit,
    output logic             hit_entry,
    output logic             next_hit,
    output logic             victim
);
    logic [FC_ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]      tag_q [FC_ENTRIES];
    logic                  mru_q;
    logic [FC_ENTRIES-1:0] match;
    logic [FC_ENTRIES-1:0] next_match;

    for (genvar e = 0; e < FC_ENTRIES; e++) begin : g_cmp
        assign match[e]      = valid_q[e] && (tag_q[e] == lookup_tag);
        assign next_match[e] = valid_q[e] && (tag_q[e] == next_tag);
    end

    assign hit       = |match;
    assign hit_entry = match[1];
    assign next_hit  = |next_match;
    assign victim    = ~mru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            mru_q   <= 1'b0;
            for (int e = 0; e < FC_ENTRIES; e++) tag_q[e] <= '0;
        end else begin
            if (clear_all) begin
                valid_q <= '0;
            end else begin
                if (alloc)  valid_q[alloc_entry]  <= 1'b0;
                if (commit) valid_q[commit_entry] <= 1'b1;
            end
            if (alloc) tag_q[alloc_entry] <= alloc_tag;
            if (touch) mru_q <= touch_entry;
        end
    end

    // R5 / R8: a clear leaves nothing valid in the following cycle
    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (valid_q == '0));

    // R3: a line is never held in both entries
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);
endmodule

// File: rtl/fc_line_store.sv
module fc_line_store
    import fc_pkg::*;
#(
    parameter int WPL    = 16,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_entry,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_entry,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [FC_ENTRIES][WPL];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_entry][wr_word] <= wr_data;
    end

    assign rd_data = mem_q[rd_entry][rd_word];
endmodule

// File: rtl/fc_flash_line_cache.sv
module fc_flash_line_cache
    import fc_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        policy,
    input  logic              host_req_valid,
    input  logic [ADDR_W-1:0] host_req_addr,
    input  logic              host_write,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              fl_req_valid,
    output logic [ADDR_W-1:0] fl_req_addr,
    output logic              fl_req_line,
    input  logic              fl_req_ready,
    input  logic              fl_rsp_valid,
    input  logic [DATA_W-1:0] fl_rsp_data
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WPL        = LINE_BYTES / WORD_BYTES;
    localparam int OFF_W      = $clog2(WPL);
    localparam int LSB_W      = $clog2(LINE_BYTES);
    localparam int BYTE_W     = $clog2(WORD_BYTES);
    localparam int TAG_W      = ADDR_W - LSB_W;

    fc_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              entry_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              kill_q;
    logic              pf_pend_q;
    logic [TAG_W-1:0]  pf_tag_q;
    logic              pf_entry_q;
    logic [DATA_W-1:0] rdata_q;

    logic              cacheable, prefetch_on, inv_now;
    logic [TAG_W-1:0]  lookup_tag, next_tag;
    logic [OFF_W-1:0]  host_off, req_off;
    logic              hit, hit_entry, next_hit, victim;
    logic              accept, alloc, commit, last_word, fill_wr;
    logic [DATA_W-1:0] store_rd;

    assign cacheable   = (policy != POL_PASS);
    assign prefetch_on = (policy == POL_PREF);
    assign inv_now     = host_write || (policy == POL_PASS);
    assign lookup_tag  = host_req_addr[ADDR_W-1:LSB_W];
    assign next_tag    = lookup_tag + TAG_W'(1);
    assign host_off    = host_req_addr[LSB_W-1:BYTE_W];
    assign req_off     = addr_q[LSB_W-1:BYTE_W];

    assign accept    = (state_q == ST_IDLE) && host_req_valid;
    assign fill_wr   = ((state_q == ST_DFILL) || (state_q == ST_PFILL)) && fl_rsp_valid;
    assign last_word = fill_wr && (cnt_q == OFF_W'(WPL - 1));
    assign alloc     = (accept && cacheable && !hit) || ((state_q == ST_RESP) && pf_pend_q);
    assign commit    = last_word && !kill_q && !inv_now;

    fc_tag_track #(.TAG_W(TAG_W)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .lookup_tag   (lookup_tag),
        .next_tag     (next_tag),
        .clear_all    (inv_now),
        .alloc        (alloc),
        .alloc_entry  ((state_q == ST_IDLE) ? victim : pf_entry_q),
        .alloc_tag    ((state_q == ST_IDLE) ? lookup_tag : pf_tag_q),
        .commit       (commit),
        .commit_entry (entry_q),
        .touch        (accept && cacheable),
        .touch_entry  (hit ? hit_entry : victim),
        .hit          (hit),
        .hit_entry    (hit_entry),
        .next_hit     (next_hit),
        .victim       (victim)
    );

    fc_line_store #(.WPL(WPL), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .wr_en    (fill_wr),
        .wr_entry (entry_q),
        .wr_word  (cnt_q),
        .wr_data  (fl_rsp_data),
        .rd_entry (hit_entry),
        .rd_word  (host_off),
        .rd_data  (store_rd)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (host_req_valid) begin
                if (!cacheable) state_d = ST_WREQ;
                else if (hit)   state_d = ST_RESP;
                else            state_d = ST_DREQ;
            end
            ST_DREQ:  if (fl_req_ready) state_d = ST_DFILL;
            ST_DFILL: if (last_word)    state_d = ST_RESP;
            ST_WREQ:  if (fl_req_ready) state_d = ST_WWAIT;
            ST_WWAIT: if (fl_rsp_valid) state_d = ST_RESP;
            ST_RESP:  state_d = pf_pend_q ? ST_PREQ : ST_IDLE;
            ST_PREQ:  if (fl_req_ready) state_d = ST_PFILL;
            ST_PFILL: if (last_word)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            entry_q    <= 1'b0;
            cnt_q      <= '0;
            kill_q     <= 1'b0;
            pf_pend_q  <= 1'b0;
            pf_tag_q   <= '0;
            pf_entry_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q    <= host_req_addr;
                pf_pend_q <= 1'b0;
                if (cacheable && hit) begin
                    rdata_q    <= store_rd;
                    pf_pend_q  <= prefetch_on && !next_hit;
                    pf_tag_q   <= next_tag;
                    pf_entry_q <= ~hit_entry;
                end else if (cacheable) begin
                    entry_q <= victim;
                    kill_q  <= inv_now;
                end
            end
            if (state_q == ST_RESP && pf_pend_q) begin
                entry_q   <= pf_entry_q;
                kill_q    <= inv_now;
                pf_pend_q <= 1'b0;
            end
            if (state_q == ST_DREQ || state_q == ST_DFILL ||
                state_q == ST_PREQ || state_q == ST_PFILL) begin
                if (inv_now) kill_q <= 1'b1;
            end
            if (fill_wr) begin
                cnt_q <= cnt_q + OFF_W'(1);
                if (state_q == ST_DFILL && cnt_q == req_off) rdata_q <= fl_rsp_data;
            end
            if (state_q == ST_WWAIT && fl_rsp_valid) rdata_q <= fl_rsp_data;
        end
    end

    // outputs
    always_comb begin
        fl_req_valid = 1'b0;
        fl_req_line  = 1'b0;
        fl_req_addr  = '0;
        unique case (state_q)
            ST_DREQ: begin
                fl_req_valid = 1'b1;
                fl_req_line  = 1'b1;
                fl_req_addr  = {addr_q[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
            end
            ST_WREQ: begin
                fl_req_valid = 1'b1;
                fl_req_addr  = addr_q;
            end
            ST_PREQ: begin
                fl_req_valid = 1'b1;
                fl_req_line  = 1'b1;
                fl_req_addr  = {pf_tag_q, {LSB_W{1'b0}}};
            end
            default: ;
        endcase
    end

    assign host_ready = (state_q == ST_RESP);
    assign host_rdata = rdata_q;

    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_valid && !fl_req_ready) |=>
            (fl_req_valid && $stable(fl_req_addr) && $stable(fl_req_line)));

    assert_line_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_valid && fl_req_line) |-> (fl_req_addr[LSB_W-1:0] == '0));

    assert_pass_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && host_req_valid && policy == POL_PASS) |=>
            (fl_req_valid && !fl_req_line));
endmodule

// File: tb/fc_flash_line_cache_tb_top.sv
`timescale 1ns/1ps
module fc_flash_line_cache_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  policy;
    logic        host_req_valid;
    logic [23:0] host_req_addr;
    logic        host_write;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        fl_req_valid;
    logic [23:0] fl_req_addr;
    logic        fl_req_line;
    logic        fl_req_ready;
    logic        fl_rsp_valid;
    logic [31:0] fl_rsp_data;

    int          tests = 0;
    int          fails = 0;
    logic [7:0]  gen = 8'h01;
    int          req_cnt = 0;
    logic [23:0] log_addr [32];
    logic        log_line [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    fc_flash_line_cache dut_i (
        .clk(clk), .rst_n(rst_n), .policy(policy),
        .host_req_valid(host_req_valid), .host_req_addr(host_req_addr),
        .host_write(host_write), .host_ready(host_ready), .host_rdata(host_rdata),
        .fl_req_valid(fl_req_valid), .fl_req_addr(fl_req_addr), .fl_req_line(fl_req_line),
        .fl_req_ready(fl_req_ready), .fl_rsp_valid(fl_rsp_valid), .fl_rsp_data(fl_rsp_data)
    );

    function automatic logic [31:0] word_of(input logic [7:0] g, input logic [23:0] a);
        return {g, a[23:2], 2'b00};
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // flash engine model
    initial begin
        fl_rsp_valid = 1'b0;
        fl_rsp_data  = '0;
        forever begin
            @(negedge clk); #1;
            if (fl_req_valid && fl_req_ready) begin
                automatic int          nw   = fl_req_line ? 16 : 1;
                automatic logic [23:0] base = fl_req_addr;
                if (req_cnt < 32) begin
                    log_addr[req_cnt] = fl_req_addr;
                    log_line[req_cnt] = fl_req_line;
                end
                req_cnt++;
                @(negedge clk);
                @(negedge clk);
                for (int i = 0; i < nw; i++) begin
                    fl_rsp_valid = 1'b1;
                    fl_rsp_data  = word_of(gen, base + 24'(4 * i));
                    @(negedge clk);
                end
                fl_rsp_valid = 1'b0;
            end
        end
    end

    task automatic host_read(input logic [23:0] a, output logic [31:0] d, output int cyc);
        @(negedge clk);
        host_req_valid = 1'b1;
        host_req_addr  = a;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ready && cyc < 300);
        d = host_rdata;
        host_req_valid = 1'b0;
    endtask

    task automatic pulse_write();
        @(negedge clk); host_write = 1'b1;
        @(negedge clk); host_write = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready in reset", 32'(host_ready), 0);
        chk("R1 req in reset", 32'(fl_req_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(host_ready), 0);
        chk("R1 req after reset", 32'(fl_req_valid), 0);
    endtask

    task automatic t_miss_fill();
        logic [31:0] d; int c; int n0;
        policy = 2'b00; gen = 8'h01; n0 = req_cnt;
        host_read(24'h001048, d, c);
        chk("R1/R2 miss request count", 32'(req_cnt - n0), 1);
        chk("R2 line address", 32'(log_addr[n0]), 32'h001040);
        chk("R2 line flag", 32'(log_line[n0]), 1);
        chk("R2 selected word", d, word_of(8'h01, 24'h001048));
        @(negedge clk);
        chk("R12 ready single pulse", 32'(host_ready), 0);
    endtask

    task automatic t_hit();
        logic [31:0] d; int c; int n0;
        gen = 8'h02; n0 = req_cnt;
        host_read(24'h00107C, d, c);
        chk("R3 hit no request", 32'(req_cnt - n0), 0);
        chk("R3 hit latency", 32'(c), 1);
        chk("R3 hit data from buffer", d, word_of(8'h01, 24'h00107C));
    endtask

    task automatic t_pass();
        logic [31:0] d; int c; int n0;
        policy = 2'b01; n0 = req_cnt;
        host_read(24'h001050, d, c);
        host_read(24'h001050, d, c);
        chk("R4 one request per read", 32'(req_cnt - n0), 2);
        chk("R4 word flag", 32'(log_line[n0 + 1]), 0);
        chk("R4 word address", 32'(log_addr[n0 + 1]), 32'h001050);
        chk("R4 pass data", d, word_of(8'h02, 24'h001050));
    endtask

    task automatic t_pass_invalidates();
        logic [31:0] d; int c; int n0;
        policy = 2'b00; gen = 8'h03; n0 = req_cnt;
        host_read(24'h001044, d, c);
        chk("R5 refetch after pass-through", 32'(req_cnt - n0), 1);
        chk("R5 fresh data", d, word_of(8'h03, 24'h001044));
    endtask

    task automatic t_write_inv();
        logic [31:0] d; int c; int n0;
        pulse_write();
        gen = 8'h04; n0 = req_cnt;
        host_read(24'h001044, d, c);
        chk("R8 refetch after write", 32'(req_cnt - n0), 1);
        chk("R8 fresh data", d, word_of(8'h04, 24'h001044));
    endtask

    task automatic t_prefetch();
        logic [31:0] d; int c; int n0;
        policy = 2'b10; gen = 8'h06;
        host_read(24'h002000, d, c);
        n0 = req_cnt;
        host_read(24'h002004, d, c);
        chk("R6 hit returns before prefetch", 32'(req_cnt - n0), 0);
        settle();
        chk("R6 prefetch issued", 32'(req_cnt - n0), 1);
        chk("R6 prefetch address", 32'(log_addr[n0]), 32'h002040);
        chk("R6 prefetch line flag", 32'(log_line[n0]), 1);
        gen = 8'h07; n0 = req_cnt;
        host_read(24'h002048, d, c);
        chk("R6 prefetched line hits", 32'(req_cnt - n0), 0);
        chk("R6 prefetched data", d, word_of(8'h06, 24'h002048));
        settle();
    endtask

    task automatic t_no_repeat_pf();
        logic [31:0] d; int c; int n0;
        n0 = req_cnt;
        host_read(24'h002044, d, c);
        settle();
        chk("R10 next line present, no prefetch", 32'(req_cnt - n0), 0);
        chk("R10 hit data", d, word_of(8'h06, 24'h002044));
    endtask

    task automatic t_order();
        logic [31:0] d; int c; int n0;
        pulse_write();
        gen = 8'h08;
        host_read(24'h003000, d, c);
        n0 = req_cnt;
        host_read(24'h003000, d, c);
        host_read(24'h005010, d, c);
        chk("R9 two requests", 32'(req_cnt - n0), 2);
        chk("R9 prefetch first", 32'(log_addr[n0]), 32'h003040);
        chk("R9 demand second", 32'(log_addr[n0 + 1]), 32'h005000);
        chk("R9 demand data", d, word_of(8'h08, 24'h005010));
        settle();
    endtask

    task automatic t_reserved();
        logic [31:0] d; int c; int n0;
        policy = 2'b11;
        pulse_write();
        n0 = req_cnt;
        host_read(24'h004000, d, c);
        host_read(24'h004004, d, c);
        settle();
        chk("R7 reserved policy no prefetch", 32'(req_cnt - n0), 1);
        chk("R7 hit data", d, word_of(8'h08, 24'h004004));
    endtask

    task automatic t_hold();
        logic [23:0] a0; int n0; int c;
        policy = 2'b01; fl_req_ready = 1'b0; gen = 8'h09; n0 = req_cnt;
        @(negedge clk);
        host_req_valid = 1'b1;
        host_req_addr  = 24'h006008;
        @(negedge clk); @(negedge clk);
        a0 = fl_req_addr;
        repeat (5) @(negedge clk);
        chk("R11 request held", 32'(fl_req_valid), 1);
        chk("R11 address stable", 32'(fl_req_addr), 32'(a0));
        chk("R11 word flag stable", 32'(fl_req_line), 0);
        fl_req_ready = 1'b1;
        c = 0;
        while (!host_ready && c < 300) begin @(negedge clk); c++; end
        chk("R11 data after acceptance", host_rdata, word_of(8'h09, 24'h006008));
        host_req_valid = 1'b0;
        chk("R11 single request", 32'(req_cnt - n0), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; policy = 2'b00; host_req_valid = 1'b0; host_req_addr = '0;
        host_write = 1'b0; fl_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_miss_fill();
        t_hit();
        t_pass();
        t_pass_invalidates();
        t_write_inv();
        t_prefetch();
        t_no_repeat_pf();
        t_order();
        t_reserved();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule